// File: doc/BRIEF.md
# Sectored Instruction Cache with Parity Recovery

This block is a direct-mapped instruction cache. Each line is split into four sectors, and each sector holds eight 32-bit instruction words. Every word carries five predecode bits and one parity bit. A fetch presents a line index taken from the fetch address, a physical tag and a sector number. On a hit the cache returns the whole sector: eight instructions and their predecode bits.

On a miss the cache asks the next level for the line, critical sector first. The line arrives over a 32-byte-per-beat fill bus in wrap-around order, and the waiting fetch is answered as soon as its own sector is written. The other sectors keep arriving in the background. Fetches that find their sector already valid may hit during that time. A fetch that does not hit while the fill is still running waits for the fill to end and is then looked up again.

The data array has a single port, so a fill write and a fetch read never share a cycle. A hit whose sector shows a parity error is not reported as a fault. The cache treats it as a miss: it invalidates the line and fetches it again. A test input can corrupt the stored parity of a fill beat, which lets a test exercise this recovery path.

Top module: `icache_sectored`

## Requirements
- R1: After synchronous reset, `resp_valid`, `refill_req` and `fetch_stall` are low and no sector of any line is valid, so the first fetch to any index misses.
- R2: A fetch is accepted on a rising edge where `fetch_req` is high and `fetch_stall` is low. If it hits, `resp_valid` rises after the next edge, and `resp_instr`/`resp_pdec` hold the stored words: word w sits at `resp_instr[32w+31:32w]` and `resp_pdec[5w+4:5w]`.
- R3: A missing fetch produces a one-cycle `refill_req` pulse whose `refill_idx`, `refill_tag` and `refill_sec` equal the fetch's index, tag and sector. It also clears all four sector valid bits of that line and installs the new tag.
- R4: A refill takes four `fill_valid` beats, and beat k is stored into sector (refill_sec + k) mod 4. Each beat uses the same word and predecode layout as R2.
- R5: The missing fetch is answered with `resp_valid` in the cycle after its first fill beat is written, carrying that beat's data.
- R6: The array performs one access per cycle. `fetch_stall` is high in every cycle with a fill beat, and a fetch is accepted only when `fetch_stall` is low.
- R7: While a refill is still running, a fetch to a sector of that line that has already been written hits with the R2 latency and raises no new `refill_req`.
- R8: A fetch that does not hit while a refill is in progress waits until the refill completes and is then looked up again. If the second lookup hits, no further `refill_req` is raised. If it misses, a new refill starts.
- R9: Each stored word keeps even parity over its 37 data and predecode bits. `tst_flip_par` high during a beat inverts the stored parity bit of word 0 of that beat. A later lookup of that sector finds the error and is handled as a miss: R3 refill, then correct data.
- R10: The cache is direct-mapped. A fetch to an index with a different tag evicts the resident line, and returning to the old tag misses again.
- R11: Each accepted fetch yields exactly one `resp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request |
| fetch_idx | input | 5 | Line index from the fetch address |
| fetch_tag | input | 30 | Physical tag |
| fetch_sec | input | 2 | Requested sector |
| fetch_stall | output | 1 | Request cannot be accepted this cycle |
| resp_valid | output | 1 | Response strobe |
| resp_instr | output | 256 | Eight instruction words |
| resp_pdec | output | 40 | Eight 5-bit predecode fields |
| refill_req | output | 1 | Line refill request pulse |
| refill_idx | output | 5 | Index of the line to refill |
| refill_tag | output | 30 | Tag of the line to refill |
| refill_sec | output | 2 | Critical sector, sent first |
| fill_valid | input | 1 | Fill beat present |
| fill_instr | input | 256 | Fill beat instruction words |
| fill_pdec | input | 40 | Fill beat predecode fields |
| tst_flip_par | input | 1 | Test input: corrupt the parity of word 0 of this beat |

## Verification
On every cycle, the bound checker checks four things:
- No array read ever coincides with a fill write.
- A fill beat always stalls the fetch port.
- `resp_valid` and `refill_req` are single-cycle pulses.
- The first fill beat is always followed by a response.

Other behaviours need a scenario to show them:
- Sector placement in wrap-around order.
- Hits during a background fill, and waits on unfilled sectors.
- Eviction between two tags sharing an index.
- Replay after an injected parity error.

The bench checks these against its behavioural model of tags, sector validity and corrupted sectors, and compares every response with data computed from the address.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
package icache_pkg;
  localparam int IC_SECTORS = 4;

  typedef enum logic [1:0] {
    IC_IDLE,   // ready for a fetch
    IC_LOOK,   // array output available, compare tag and parity
    IC_CRIT,   // waiting for the critical sector of a refill
    IC_HOLD    // fetch parked until the running refill ends
  } ic_state_e;
endpackage

// File: rtl/icache_data_ram.sv
`timescale 1ns/1ps
module icache_data_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 304,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/icache_tag_store.sv
`timescale 1ns/1ps
module icache_tag_store #(
  parameter int LINES = 32,
  parameter int IDX_W = 5,
  parameter int TAG_W = 30,
  parameter int SECS  = 4,
  parameter int SEC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [SECS-1:0]  rd_sv,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [SEC_W-1:0] set_sec
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [SECS-1:0]  sv_q  [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) sv_q[i] <= '0;
    end else begin
      if (inv_en) sv_q[inv_idx] <= '0;
      if (set_en) sv_q[set_idx][set_sec] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (inv_en) tag_q[inv_idx] <= inv_tag;
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_sv  = sv_q[rd_idx];
endmodule

// File: rtl/icache_fill_seq.sv
`timescale 1ns/1ps
module icache_fill_seq #(
  parameter int IDX_W = 5,
  parameter int SEC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [SEC_W-1:0] start_sec,
  input  logic             beat_in,
  output logic             active,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [SEC_W-1:0] wr_sec,
  output logic             first_beat
);
  logic [SEC_W-1:0] cnt_q;
  logic [SEC_W-1:0] crit_q;
  logic [IDX_W-1:0] idx_q;
  logic             act_q;

  assign active     = act_q;
  assign wr_en      = act_q && beat_in;
  assign wr_idx     = idx_q;
  assign wr_sec     = crit_q + cnt_q;
  assign first_beat = wr_en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (wr_en) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '1) act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      crit_q <= start_sec;
      idx_q  <= start_idx;
    end
  end
endmodule

// File: rtl/icache_sectored.sv
`timescale 1ns/1ps
module icache_sectored
  import icache_pkg::*;
#(
  parameter int  CACHE_BYTES = 4096,
  parameter int  LINE_BYTES  = 128,
  parameter int  WORDS       = 8,
  parameter int  INSTR_W     = 32,
  parameter int  PDEC_W      = 5,
  parameter int  TAG_W       = 30,
  localparam int LINES       = CACHE_BYTES / LINE_BYTES,
  localparam int IDX_W       = $clog2(LINES),
  localparam int SEC_W       = $clog2(IC_SECTORS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetch_req,
  input  logic [IDX_W-1:0]         fetch_idx,
  input  logic [TAG_W-1:0]         fetch_tag,
  input  logic [SEC_W-1:0]         fetch_sec,
  output logic                     fetch_stall,
  output logic                     resp_valid,
  output logic [WORDS*INSTR_W-1:0] resp_instr,
  output logic [WORDS*PDEC_W-1:0]  resp_pdec,
  output logic                     refill_req,
  output logic [IDX_W-1:0]         refill_idx,
  output logic [TAG_W-1:0]         refill_tag,
  output logic [SEC_W-1:0]         refill_sec,
  input  logic                     fill_valid,
  input  logic [WORDS*INSTR_W-1:0] fill_instr,
  input  logic [WORDS*PDEC_W-1:0]  fill_pdec,
  input  logic                     tst_flip_par
);
  localparam int SLOT_W = INSTR_W + PDEC_W;
  localparam int CELL_W = SLOT_W + 1;
  localparam int ROW_W  = WORDS * CELL_W;
  localparam int DEPTH  = LINES * IC_SECTORS;
  localparam int AW     = IDX_W + SEC_W;

  ic_state_e st_q;
  logic [IDX_W-1:0] p_idx_q;
  logic [TAG_W-1:0] p_tag_q;
  logic [SEC_W-1:0] p_sec_q;

  logic             fill_act, fill_wr, fill_first;
  logic [IDX_W-1:0] fill_idx;
  logic [SEC_W-1:0] fill_sec;

  logic             accept, retry, rd_en, hit, miss_new, crit_done;
  logic [AW-1:0]    rd_addr;
  logic [ROW_W-1:0] rd_row, wr_row;
  logic [WORDS-1:0] rd_err;
  logic [WORDS*INSTR_W-1:0] rd_instr;
  logic [WORDS*PDEC_W-1:0]  rd_pdec;
  logic [TAG_W-1:0]      rd_tag;
  logic [IC_SECTORS-1:0] rd_sv;

  // Port arbitration: a fill beat owns the single array port.
  assign fetch_stall = (st_q != IC_IDLE) || fill_wr;
  assign accept      = (st_q == IC_IDLE) && fetch_req && !fill_wr;
  assign retry       = (st_q == IC_HOLD) && !fill_act;
  assign rd_en       = accept || retry;
  assign rd_addr     = accept ? {fetch_idx, fetch_sec} : {p_idx_q, p_sec_q};

  // Per-word parity on write, parity check on read.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [SLOT_W-1:0] slot;
    assign slot = {fill_pdec[w*PDEC_W +: PDEC_W], fill_instr[w*INSTR_W +: INSTR_W]};
    assign wr_row[w*CELL_W +: CELL_W] = {(^slot) ^ (tst_flip_par & (w == 0)), slot};
    assign rd_err[w] = ^rd_row[w*CELL_W +: CELL_W];
    assign rd_instr[w*INSTR_W +: INSTR_W] = rd_row[w*CELL_W +: INSTR_W];
    assign rd_pdec[w*PDEC_W +: PDEC_W]    = rd_row[w*CELL_W + INSTR_W +: PDEC_W];
  end

  assign hit       = (st_q == IC_LOOK) && (rd_tag == p_tag_q) && rd_sv[p_sec_q] && !(|rd_err);
  assign miss_new  = (st_q == IC_LOOK) && !hit && !fill_act;
  assign crit_done = (st_q == IC_CRIT) && fill_first;

  icache_data_ram #(.DEPTH(DEPTH), .WIDTH(ROW_W), .AW(AW)) data_i (
    .clk(clk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_row),
    .wr_en(fill_wr), .wr_addr({fill_idx, fill_sec}), .wr_data(wr_row)
  );

  icache_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
                     .SECS(IC_SECTORS), .SEC_W(SEC_W)) tags_i (
    .clk(clk), .rst(rst), .rd_idx(p_idx_q), .rd_tag(rd_tag), .rd_sv(rd_sv),
    .inv_en(miss_new), .inv_idx(p_idx_q), .inv_tag(p_tag_q),
    .set_en(fill_wr), .set_idx(fill_idx), .set_sec(fill_sec)
  );

  icache_fill_seq #(.IDX_W(IDX_W), .SEC_W(SEC_W)) fill_i (
    .clk(clk), .rst(rst), .start(miss_new), .start_idx(p_idx_q), .start_sec(p_sec_q),
    .beat_in(fill_valid), .active(fill_act), .wr_en(fill_wr), .wr_idx(fill_idx),
    .wr_sec(fill_sec), .first_beat(fill_first)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= IC_IDLE;
      resp_valid <= 1'b0;
      refill_req <= 1'b0;
    end else begin
      resp_valid <= hit || crit_done;
      refill_req <= miss_new;
      case (st_q)
        IC_IDLE: if (accept) st_q <= IC_LOOK;
        IC_LOOK: begin
          if (hit)           st_q <= IC_IDLE;
          else if (fill_act) st_q <= IC_HOLD;
          else               st_q <= IC_CRIT;
        end
        IC_CRIT: if (fill_first) st_q <= IC_IDLE;
        IC_HOLD: if (!fill_act)  st_q <= IC_LOOK;
        default: st_q <= IC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      p_idx_q <= fetch_idx;
      p_tag_q <= fetch_tag;
      p_sec_q <= fetch_sec;
    end
    if (hit) begin
      resp_instr <= rd_instr;
      resp_pdec  <= rd_pdec;
    end else if (crit_done) begin
      resp_instr <= fill_instr;
      resp_pdec  <= fill_pdec;
    end
    if (miss_new) begin
      refill_idx <= p_idx_q;
      refill_tag <= p_tag_q;
      refill_sec <= p_sec_q;
    end
  end
endmodule

// File: rtl/icache_sectored_chk.sv
`timescale 1ns/1ps
module icache_sectored_chk (
  input logic clk,
  input logic rst,
  input logic rd_en,
  input logic fill_wr,
  input logic fill_first,
  input logic fetch_stall,
  input logic resp_valid,
  input logic refill_req
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!resp_valid && !refill_req));

  // R6
  one_port_chk: assert property (@(posedge clk) disable iff (rst) !(rd_en && fill_wr));

  // R6
  fill_stall_chk: assert property (@(posedge clk) disable iff (rst) fill_wr |-> fetch_stall);

  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst) resp_valid |=> !resp_valid);

  // R3
  refill_pulse_chk: assert property (@(posedge clk) disable iff (rst) refill_req |=> !refill_req);

  // R5
  crit_resp_chk: assert property (@(posedge clk) disable iff (rst) fill_first |=> resp_valid);
endmodule

bind icache_sectored icache_sectored_chk chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .fill_wr(fill_wr), .fill_first(fill_first),
  .fetch_stall(fetch_stall), .resp_valid(resp_valid), .refill_req(refill_req)
);

// File: tb/icache_sectored_tb_top.sv
`timescale 1ns/1ps
module icache_sectored_tb_top;
  localparam int MODE_HIT  = 0;
  localparam int MODE_MISS = 1;
  localparam int MODE_WAIT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_req = 1'b0;
  logic [4:0]  fetch_idx = '0;
  logic [29:0] fetch_tag = '0;
  logic [1:0]  fetch_sec = '0;
  logic fetch_stall, resp_valid, refill_req;
  logic [255:0] resp_instr;
  logic [39:0]  resp_pdec;
  logic [4:0]  refill_idx;
  logic [29:0] refill_tag;
  logic [1:0]  refill_sec;
  logic fill_valid = 1'b0;
  logic [255:0] fill_instr = '0;
  logic [39:0]  fill_pdec = '0;
  logic tst_flip_par = 1'b0;

  int checks = 0;
  int fails = 0;
  int mem_lat = 3;
  int mem_gap = 0;
  int flip_sec = -1;
  logic [29:0] mtag [32];
  bit   [3:0]  mval [32];
  bit   [3:0]  mbad [32];

  always #4 clk = ~clk;

  icache_sectored dut_i (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_idx(fetch_idx),
    .fetch_tag(fetch_tag), .fetch_sec(fetch_sec), .fetch_stall(fetch_stall),
    .resp_valid(resp_valid), .resp_instr(resp_instr), .resp_pdec(resp_pdec),
    .refill_req(refill_req), .refill_idx(refill_idx), .refill_tag(refill_tag),
    .refill_sec(refill_sec), .fill_valid(fill_valid), .fill_instr(fill_instr),
    .fill_pdec(fill_pdec), .tst_flip_par(tst_flip_par)
  );

  function automatic logic [255:0] gi(logic [29:0] tag, logic [4:0] idx, logic [1:0] sec);
    logic [255:0] r;
    for (int w = 0; w < 8; w++)
      r[w*32 +: 32] = ({2'b0, tag} * 32'h9E3779B1) ^ {idx, sec, 3'(w), 22'h1A5C3};
    return r;
  endfunction

  function automatic logic [39:0] gp(logic [29:0] tag, logic [4:0] idx, logic [1:0] sec);
    logic [39:0] r;
    for (int w = 0; w < 8; w++)
      r[w*5 +: 5] = (tag[4:0] ^ {idx[2:0], sec}) + 5'(w);
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", rq, act, exp);
    end
  endtask

  // Next-level memory: four beats, critical sector first, wrapping.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (refill_req) begin
        logic [4:0] ridx; logic [29:0] rtag; logic [1:0] rcrit;
        ridx = refill_idx; rtag = refill_tag; rcrit = refill_sec;
        repeat (mem_lat) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          logic [1:0] s;
          s = rcrit + 2'(b);
          fill_valid = 1'b1;
          fill_instr = gi(rtag, ridx, s);
          fill_pdec = gp(rtag, ridx, s);
          tst_flip_par = (int'(s) == flip_sec);
          @(negedge clk);
          fill_valid = 1'b0;
          tst_flip_par = 1'b0;
          if (b < 3) repeat (mem_gap) @(negedge clk);
        end
        flip_sec = -1;
      end
    end
  end

  // Every-cycle comparison: fill beats stall fetches, responses are single pulses.
  initial begin
    bit prev = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (!rst) begin
        if (fill_valid) chk(fetch_stall === 1'b1, "R6 stall on fill beat", $sformatf("%b", fetch_stall), "1");
        if (resp_valid) chk(!prev, "R11 single-cycle response", "2 cycles", "1 cycle");
        prev = resp_valid;
      end
    end
  end

  task automatic do_fetch(input logic [4:0] idx, input logic [29:0] tag, input logic [1:0] sec,
                          input int mode, input string rq);
    bit acc = 0; bit saw = 0; bit ok_ref = 1; int lat = 0; int fl;
    fl = flip_sec;
    while (!acc) begin
      @(negedge clk); #1;
      fetch_req = 1'b1; fetch_idx = idx; fetch_tag = tag; fetch_sec = sec;
      acc = !fetch_stall;
      @(posedge clk);
    end
    #1 fetch_req = 1'b0;
    do begin
      @(posedge clk); #1;
      lat++;
      if (refill_req) begin
        saw = 1;
        if (refill_idx !== idx || refill_tag !== tag || refill_sec !== sec) ok_ref = 0;
      end
    end while (!resp_valid && lat < 500);
    chk(resp_valid === 1'b1 && resp_instr === gi(tag, idx, sec) && resp_pdec === gp(tag, idx, sec),
        {rq, " data"}, $sformatf("%h/%h", resp_instr, resp_pdec),
        $sformatf("%h/%h", gi(tag, idx, sec), gp(tag, idx, sec)));
    case (mode)
      MODE_HIT:  chk(lat == 1 && !saw, {rq, " hit"}, $sformatf("lat=%0d refill=%0d", lat, saw), "lat=1 refill=0");
      MODE_MISS: begin
        chk(saw && ok_ref, {rq, " refill request"}, $sformatf("refill=%0d fields_ok=%0d", saw, ok_ref), "refill=1 fields_ok=1");
        mtag[idx] = tag;
        mval[idx] = 4'hF;
        mbad[idx] = (fl >= 0) ? 4'(1 << fl) : 4'h0;
      end
      default:   chk(!saw && lat > 1, {rq, " wait"}, $sformatf("lat=%0d refill=%0d", lat, saw), "lat>1 refill=0");
    endcase
  endtask

  task automatic fetch_auto(input logic [4:0] idx, input logic [29:0] tag, input logic [1:0] sec,
                            input string rq);
    int mode;
    mode = (mval[idx][sec] && mtag[idx] == tag && !mbad[idx][sec]) ? MODE_HIT : MODE_MISS;
    do_fetch(idx, tag, sec, mode, rq);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin mval[i] = 0; mbad[i] = 0; mtag[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk(!resp_valid && !refill_req && !fetch_stall, "R1 reset outputs",
        $sformatf("%b%b%b", resp_valid, refill_req, fetch_stall), "000");

    // R1/R3/R5 cold miss, critical sector 2
    fetch_auto(5'd5, 30'h0001234, 2'd2, "R3 R5 cold miss");
    settle();
    // R2/R4 all sectors hit after wrap-around fill
    for (int s = 0; s < 4; s++) fetch_auto(5'd5, 30'h0001234, 2'(s), "R2 R4 hit after fill");

    // R10 direct-mapped eviction
    fetch_auto(5'd5, 30'h2ABCDEF, 2'd0, "R10 evict");
    settle();
    fetch_auto(5'd5, 30'h0001234, 2'd1, "R10 old tag misses");
    settle();

    // R7/R8 background fill with gaps between beats
    mem_gap = 6;
    fetch_auto(5'd9, 30'h0777000, 2'd1, "R5 critical response");
    do_fetch(5'd9, 30'h0777000, 2'd1, MODE_HIT, "R7 hit during fill");
    do_fetch(5'd9, 30'h0777000, 2'd0, MODE_WAIT, "R8 wait for unfilled sector");
    settle();
    // R8 miss to another line while a fill runs
    fetch_auto(5'd14, 30'h0055AA0, 2'd0, "R8 first miss");
    fetch_auto(5'd15, 30'h0055AA0, 2'd3, "R8 queued miss");
    settle();
    mem_gap = 0;

    // R9 parity error on sector 1, fill started at sector 3
    flip_sec = 1;
    fetch_auto(5'd20, 30'h1357BDF, 2'd3, "R4 R9 fill with flip");
    settle();
    fetch_auto(5'd20, 30'h1357BDF, 2'd0, "R9 clean sector hit");
    fetch_auto(5'd20, 30'h1357BDF, 2'd1, "R9 parity replay");
    settle();
    fetch_auto(5'd20, 30'h1357BDF, 2'd1, "R9 hit after reload");
    fetch_auto(5'd20, 30'h1357BDF, 2'd2, "R9 neighbour hit");

    // boundary index and tag
    fetch_auto(5'd31, 30'h3FFFFFFF, 2'd3, "R3 top index miss");
    settle();
    fetch_auto(5'd31, 30'h3FFFFFFF, 2'd0, "R2 top index hit");

    settle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule